// File: doc/BRIEF.md
# Buffered Serial Word Receiver

The block takes serial data from three pins: a bit clock, a frame sync and a data line. All three run asynchronously to the system clock. They are brought into the system clock domain, and the selected edge of the bit clock is detected there. When a frame sync is seen on that edge, a word starts. Its bits are then taken MSB first, one per active edge, into a shift register.

A finished word moves into a holding register. It moves from there into the host-visible data register once that register is empty. This leaves room for two complete words, plus a third still being shifted, before data is lost.

Word length, bit-clock edge and frame-sync level are chosen at run time. An optional expander turns an 8-bit mu-law or A-law code into a sign-extended two's complement sample. Each time the data register fills, one pulse is given on the interrupt line and one on the DMA request line.

Top module: `rx_serial_buf`

## Requirements
- R1: After reset, rdy_o, ovr_o, irq_o and evt_o are low and rd_data_o is zero.
- R2: A word starts when the frame sync is active at an active bit-clock edge. The first data bit is taken on the next active edge, and bits arrive MSB first. Active edges with no frame sync before them produce no word.
- R3: wlen_sel_i selects the word length. Codes 0, 1, 2, 3, 4 and 5 give 8, 12, 16, 20, 24 and 32 bits. Codes 6 and 7 give 32 bits. Words are right-justified and zero-extended.
- R4: clk_pol_i = 0 samples on the rising edge of sclk_i. clk_pol_i = 1 samples on the falling edge.
- R5: fs_pol_i = 0 makes fsync_i active high. fs_pol_i = 1 makes it active low.
- R6: An active frame sync in the middle of a word discards the partial word and restarts. A frame sync on the edge that takes the last bit completes that word and starts the next one with no gap.
- R7: With cmp_en_i = 1, the low 8 bits of the word are expanded to a 16-bit signed sample, sign-extended to the data width. cmp_law_i = 0 selects mu-law and cmp_law_i = 1 selects A-law.
- R8: A finished word goes to the holding register. It moves to the data register only when the data register is empty, and rdy_o then rises. A read (rd_en_i while rdy_o is high) clears rdy_o on the next cycle. Two unread words are held without overrun and are read in arrival order.
- R9: A word that finishes while the holding register and the data register are both full is dropped, and ovr_o is set. ovr_o stays set until a read. A set in the same cycle as a read takes priority over the clear.
- R10: irq_o and evt_o each pulse high for exactly one cycle, in the cycle in which rdy_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data |
| clk_pol_i | input | 1 | Sampling edge: 0 = rising, 1 = falling |
| fs_pol_i | input | 1 | Frame sync level: 0 = active high, 1 = active low |
| wlen_sel_i | input | 3 | Word length code |
| cmp_en_i | input | 1 | Enable companding expansion |
| cmp_law_i | input | 1 | Expansion law: 0 = mu-law, 1 = A-law |
| rd_en_i | input | 1 | Host read strobe for the data register |
| rd_data_o | output | DATA_W | Data register |
| rdy_o | output | 1 | Data register holds an unread word |
| ovr_o | output | 1 | A word was dropped |
| irq_o | output | 1 | Receive interrupt pulse |
| evt_o | output | 1 | DMA request pulse |

## Verification
The two events that can land in the same cycle are a word finishing into full buffers and the host reading the data register. Either order decides whether the newest word survives. The bench fills both registers, streams a third word, and issues the read at a sweep of offsets around the final bit, resetting between offsets. Each offset is judged by conservation: the words read back plus a seen overrun must account for all three words, the overrun must switch on monotonically as the read moves later, and the flag must be clear after the next read.

// File: rtl/rx_serial_pkg.sv
package rx_serial_pkg;

  typedef enum logic [2:0] {
    WL_8  = 3'd0,
    WL_12 = 3'd1,
    WL_16 = 3'd2,
    WL_20 = 3'd3,
    WL_24 = 3'd4,
    WL_32 = 3'd5
  } wlen_e;

  function automatic int unsigned wlen_bits(input logic [2:0] sel, input int unsigned max_w);
    int unsigned n;
    case (sel)
      WL_8:    n = 8;
      WL_12:   n = 12;
      WL_16:   n = 16;
      WL_20:   n = 20;
      WL_24:   n = 24;
      default: n = 32;
    endcase
    return (n > max_w) ? max_w : n;
  endfunction

endpackage

// File: rtl/rx_pin_sync.sv
module rx_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic fsync_i,
  input  logic sdata_i,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  output logic edge_o,
  output logic fs_act_o,
  output logic bit_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] stg [SYNC_STAGES];
  logic [NSIG-1:0] pins;
  logic            sclk_prev;

  assign pins = {sclk_i, fsync_i, sdata_i};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= pins;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev <= 1'b0;
    else         sclk_prev <= stg[SYNC_STAGES-1][2];
  end

  // active level after the edge is the inverse of the idle level
  assign edge_o   = (stg[SYNC_STAGES-1][2] != sclk_prev) && (stg[SYNC_STAGES-1][2] == ~clk_pol_i);
  assign fs_act_o = stg[SYNC_STAGES-1][1] ^ fs_pol_i;
  assign bit_o    = stg[SYNC_STAGES-1][0];

endmodule

// File: rtl/rx_shift.sv
module rx_shift
  import rx_serial_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              fs_i,
  input  logic              bit_i,
  input  logic [2:0]        wlen_sel_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, sr_next;
  logic [CNT_W-1:0]  nbits;
  logic              last_bit;

  assign nbits    = CNT_W'(wlen_bits(wlen_sel_i, DATA_W));
  assign sr_next  = {sr_q[DATA_W-2:0], bit_i};
  assign last_bit = active_q && (cnt_q == nbits - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      done_o   <= 1'b0;
      word_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (edge_i) begin
        if (last_bit) begin
          done_o <= 1'b1;
          word_o <= sr_next;
        end
        if (fs_i) begin
          // frame sync restarts, even mid-word
          active_q <= 1'b1;
          cnt_q    <= '0;
          sr_q     <= '0;
        end else if (active_q) begin
          sr_q  <= sr_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_bit) active_q <= 1'b0;
        end
      end
    end
  end

  assert_done_on_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(edge_i));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < nbits));

endmodule

// File: rtl/law_expand.sv
module law_expand (
  input  logic [7:0]  code_i,
  input  logic        law_i,
  output logic [15:0] sample_o
);
  logic [7:0]  mu_c, a_c;
  logic [15:0] mu_t, a_t;

  assign mu_c = ~code_i;
  assign a_c  = code_i ^ 8'h55;

  always_comb begin
    mu_t = (16'({mu_c[3:0], 3'b000}) + 16'd132) << mu_c[6:4];
    if (a_c[6:4] == 3'd0) a_t = 16'({a_c[3:0], 4'b0000}) + 16'd8;
    else                  a_t = (16'({a_c[3:0], 4'b0000}) + 16'd264) << (a_c[6:4] - 3'd1);

    if (law_i) sample_o = a_c[7] ? a_t : (16'd0 - a_t);
    else       sample_o = mu_c[7] ? (16'd132 - mu_t) : (mu_t - 16'd132);
  end

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              fill_o
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              move, take;

  assign move = hold_full_q && !rdy_o;
  assign take = rd_i && rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      data_o      <= '0;
      rdy_o       <= 1'b0;
      ovr_o       <= 1'b0;
      fill_o      <= 1'b0;
    end else begin
      fill_o <= move;
      if (move) begin
        data_o <= hold_q;
        rdy_o  <= 1'b1;
      end else if (take) begin
        rdy_o  <= 1'b0;
      end

      if (done_i && (!hold_full_q || move)) begin
        hold_q      <= word_i;
        hold_full_q <= 1'b1;
      end else if (move) begin
        hold_full_q <= 1'b0;
      end

      // set beats clear
      if (done_i && hold_full_q && !move) ovr_o <= 1'b1;
      else if (take)                      ovr_o <= 1'b0;
    end
  end

  assert_ovr_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(done_i));

  assert_drop_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && hold_full_q && rdy_o) |=> ovr_o);

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rdy_o) |=> !rdy_o);

  assert_fill_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> fill_o);

  assert_fill_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |=> !fill_o);

endmodule

// File: rtl/rx_serial_buf.sv
module rx_serial_buf #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic              clk_pol_i,
  input  logic              fs_pol_i,
  input  logic [2:0]        wlen_sel_i,
  input  logic              cmp_en_i,
  input  logic              cmp_law_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rdy_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              evt_o
);
  localparam int unsigned EXT_W = DATA_W - 16;

  logic              s_edge, s_fs, s_bit;
  logic              done;
  logic [DATA_W-1:0] raw_word, out_word;
  logic [15:0]       exp_sample;
  logic              fill;

  rx_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .fsync_i, .sdata_i, .clk_pol_i, .fs_pol_i,
    .edge_o(s_edge), .fs_act_o(s_fs), .bit_o(s_bit)
  );

  rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .edge_i(s_edge), .fs_i(s_fs), .bit_i(s_bit),
    .wlen_sel_i, .done_o(done), .word_o(raw_word)
  );

  law_expand u_exp (
    .code_i(raw_word[7:0]), .law_i(cmp_law_i), .sample_o(exp_sample)
  );

  assign out_word = cmp_en_i ? {{EXT_W{exp_sample[15]}}, exp_sample} : raw_word;

  rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .done_i(done), .word_i(out_word), .rd_i(rd_en_i),
    .data_o(rd_data_o), .rdy_o, .ovr_o, .fill_o(fill)
  );

  assign irq_o = fill;
  assign evt_o = fill;

  assert_irq_needs_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdy_o && !$past(rdy_o)));

endmodule

// File: tb/rx_serial_buf_test.sv
module rx_serial_buf_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic        cpol = 1'b0, fpol = 1'b0;
  logic [2:0]  wsel = 3'd0;
  logic        cmp_en = 1'b0, cmp_law = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rdy, ovr, irq, evt;

  int tests = 0, fails = 0;
  int irq_cnt = 0, evt_cnt = 0;
  logic ovr_seen = 1'b0;

  always #10 clk = ~clk;

  rx_serial_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .fsync_i(fsync), .sdata_i(sdata),
    .clk_pol_i(cpol), .fs_pol_i(fpol), .wlen_sel_i(wsel), .cmp_en_i(cmp_en),
    .cmp_law_i(cmp_law), .rd_en_i(rd_en), .rd_data_o(rd_data), .rdy_o(rdy),
    .ovr_o(ovr), .irq_o(irq), .evt_o(evt)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (evt) evt_cnt <= evt_cnt + 1;
    if (ovr) ovr_seen <= 1'b1;
  end

  typedef struct packed {
    logic [2:0]  wl;
    logic        cmp;
    logic        law;
    logic        cp;
    logic        fp;
    logic [31:0] din;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h000000A5, 32'h000000A5},
    '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000ABC, 32'h00000ABC},
    '{3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00008001, 32'h00008001},
    '{3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h000F0F0F, 32'h000F0F0F},
    '{3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00123456, 32'h00123456},
    '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'hDEADBEEF},
    '{3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 32'h80000001, 32'h80000001},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h000000FF, 32'h00000000},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00000000, 32'hFFFF8284},
    '{3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00000080, 32'h00007D7C},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h000000E5, 32'h00000124},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000000D5, 32'h00000008},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h00000055, 32'hFFFFFFF8},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000000AA, 32'h00007E00},
    '{3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000002A, 32'hFFFF8200},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000000E5, 32'h00000420}
  };

  function automatic int bits_of(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sclk = cpol; fsync = fpol; sdata = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic slot(input logic fs, input logic b);
    sdata = b;
    fsync = fs ^ fpol;
    repeat (4) @(negedge clk);
    sclk = ~cpol;
    repeat (4) @(negedge clk);
    sclk = cpol;
  endtask

  task automatic send_word(input logic [31:0] v, input int n, input logic fs_first, input logic fs_last);
    if (fs_first) slot(1'b1, 1'b0);
    for (int i = n - 1; i >= 0; i--) slot(fs_last && (i == 0), v[i]);
    fsync = fpol;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_read(output logic [31:0] d);
    d = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic configure(input logic [2:0] wl, input logic ce, input logic lw, input logic cp, input logic fp);
    wsel = wl; cmp_en = ce; cmp_law = lw; cpol = cp; fpol = fp;
    sclk = cp; fsync = fp;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] d;
    int i0, e0, first_ovr_k;
    logic prev_ovr;

    do_reset();
    // R1 reset state
    chk(!rdy && !ovr && !irq && !evt, "R1 flags after reset", {28'd0, rdy, ovr, irq, evt}, 32'd0);
    chk(rd_data == 32'd0, "R1 data after reset", rd_data, 32'd0);

    // vector table: R3 lengths, R4/R5 polarity, R7 expansion, R8/R10 handoff
    for (int v = 0; v < NV; v++) begin
      configure(VECS[v].wl, VECS[v].cmp, VECS[v].law, VECS[v].cp, VECS[v].fp);
      i0 = irq_cnt; e0 = evt_cnt;
      send_word(VECS[v].din, bits_of(VECS[v].wl), 1'b1, 1'b0);
      chk(rdy, "R8 ready after word", {31'd0, rdy}, 32'd1);
      chk((irq_cnt - i0 == 1) && (evt_cnt - e0 == 1), "R10 one irq/evt pulse",
          irq_cnt - i0, 32'd1);
      do_read(d);
      chk(d == VECS[v].exp, VECS[v].cmp ? "R7 expanded sample" : "R3 R4 R5 word value", d, VECS[v].exp);
      chk(!rdy, "R8 read clears ready", {31'd0, rdy}, 32'd0);
    end

    configure(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 bits without frame sync are ignored
    i0 = irq_cnt;
    for (int k = 0; k < 20; k++) slot(1'b0, k[0]);
    repeat (8) @(negedge clk);
    chk(!rdy && irq_cnt == i0, "R2 no frame sync no word", {31'd0, rdy}, 32'd0);

    // R6 restart mid-word
    slot(1'b1, 1'b0); slot(1'b0, 1'b1); slot(1'b0, 1'b1); slot(1'b0, 1'b1);
    i0 = irq_cnt;
    send_word(32'h5A, 8, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk(irq_cnt - i0 == 1, "R6 restart gives one word", irq_cnt - i0, 32'd1);
    do_read(d);
    chk(d == 32'h5A, "R6 restart value", d, 32'h5A);
    chk(!rdy, "R6 no partial word", {31'd0, rdy}, 32'd0);

    // R6 back-to-back frames, R8 two words held
    send_word(32'hC3, 8, 1'b1, 1'b1);
    send_word(32'h3C, 8, 1'b0, 1'b0);
    chk(!ovr, "R8 two words no overrun", {31'd0, ovr}, 32'd0);
    do_read(d);
    chk(d == 32'hC3, "R6 first back-to-back", d, 32'hC3);
    do_read(d);
    chk(d == 32'h3C, "R6 second back-to-back", d, 32'h3C);
    chk(!rdy, "R8 empty after two reads", {31'd0, rdy}, 32'd0);

    // R9 overrun with three unread words
    send_word(32'h01, 8, 1'b1, 1'b0);
    send_word(32'h02, 8, 1'b1, 1'b0);
    send_word(32'h03, 8, 1'b1, 1'b0);
    chk(ovr, "R9 overrun set", {31'd0, ovr}, 32'd1);
    do_read(d);
    chk(d == 32'h01, "R9 oldest kept", d, 32'h01);
    chk(!ovr, "R9 read clears overrun", {31'd0, ovr}, 32'd0);
    do_read(d);
    chk(d == 32'h02, "R9 second kept", d, 32'h02);
    chk(!rdy, "R9 third dropped", {31'd0, rdy}, 32'd0);

    // R9 read vs completion sweep
    first_ovr_k = -1;
    prev_ovr = 1'b0;
    for (int k = 40; k <= 90; k += 2) begin
      do_reset();
      send_word(32'h11, 8, 1'b1, 1'b0);
      send_word(32'h22, 8, 1'b1, 1'b0);
      ovr_seen = 1'b0;
      fork
        send_word(32'h33, 8, 1'b1, 1'b0);
        begin
          repeat (k) @(negedge clk);
          d = rd_data;
          rd_en = 1'b1;
          @(negedge clk);
          rd_en = 1'b0;
        end
      join
      repeat (8) @(negedge clk);
      chk(d == 32'h11, "R9 sweep first read", d, 32'h11);
      if (ovr_seen && !prev_ovr) first_ovr_k = k;
      chk(!(prev_ovr && !ovr_seen), "R9 overrun monotonic in read offset", {31'd0, ovr_seen}, 32'd1);
      prev_ovr = ovr_seen;
      do_read(d);
      chk(d == 32'h22, "R9 sweep second read", d, 32'h22);
      chk(!ovr, "R9 sweep overrun cleared", {31'd0, ovr}, 32'd0);
      if (ovr_seen) begin
        chk(!rdy, "R9 sweep dropped word absent", {31'd0, rdy}, 32'd0);
      end else begin
        do_read(d);
        chk(d == 32'h33, "R9 sweep third word kept", d, 32'h33);
      end
      if (k == 40) chk(!ovr_seen, "R9 early read avoids overrun", {31'd0, ovr_seen}, 32'd0);
      if (k == 90) chk(ovr_seen, "R9 late read overruns", {31'd0, ovr_seen}, 32'd1);
    end
    chk(first_ovr_k > 40, "R9 sweep crosses boundary", first_ovr_k, 32'd41);

    summary();
  end

endmodule